// File: doc/BRIEF.md
# Result FIFO with Selectable Overwrite Policy

This block sits between a converter datapath and a processor read port. It holds up to eight conversion results in arrival order. The producer offers each result with a single-cycle valid strobe. The processor takes one word per read strobe, and the word appears on the registered read-data output in the cycle after the strobe. The block keeps two sticky status flags. One records a read of an empty queue. The other records a result that arrived while the queue was full. A separate enable gates each flag onto a level-sensitive interrupt line.

A result that arrives while the queue is full is never lost. It waits in a one-word holding stage, and the block raises a stall output to the producer. Two policies govern recovery, chosen by the overwrite enable. When the enable is high, the block stops writing into the queue and keeps the stall up until software clears the overwrite flag through a status-access strobe. When the enable is low, the flag drops on its own as soon as room appears, and the held result moves into the queue in that same cycle.

Top module: `rsfifo_top`

## Requirements
- R1: The queue holds at most DEPTH (default 8) words and returns them in arrival order. `level` reports the occupancy, from 0 to DEPTH.
- R2: A read strobe while `level` is 0 sets `flag_under`. It leaves `level` unchanged and makes `rd_data` read 0 from the following cycle.
- R3: A read strobe on a non-empty queue presents the oldest word on `rd_data` in the cycle after the strobe. `rd_data` then holds that value until the next read strobe.
- R4: A result that is accepted while `level` equals DEPTH, with no read in the same cycle, sets `flag_over`. The result is kept in a holding stage and not dropped, and `prod_stall` is 1 while the holding stage is occupied.
- R5: With `over_en`=1 and `flag_over` set, nothing is written into the queue, and `prod_stall` stays 1 until the flag is cleared. The held result is written in the first cycle after the clear in which room exists.
- R6: With `over_en`=0, `flag_over` clears by itself in any cycle where `level` is below DEPTH or a read frees an entry. In that cycle the held result is written, so `level` stays at DEPTH after a read from a full queue with a held word.
- R7: A read and a write in the same cycle leave `level` unchanged, including at `level`=DEPTH. That case does not set `flag_over`.
- R8: A cycle with `stat_wr`=1 clears `flag_under` when `stat_clr[0]`=1 and clears `flag_over` when `stat_clr[1]`=1. A set event in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when (`flag_under` and `under_en`) or (`flag_over` and `over_en`).
- R10: A `prod_valid` strobe in a cycle where `prod_stall` is 1 is ignored. The word never enters the queue.
- R11: A synchronous `rst` empties the queue, clears both flags, drops `prod_stall` and returns `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_valid | input | 1 | Producer offers a result this cycle |
| prod_data | input | DATA_W | Result word |
| prod_stall | output | 1 | Producer must hold off |
| rd_en | input | 1 | Processor read strobe |
| rd_data | output | DATA_W | Word taken by the previous read strobe |
| stat_wr | input | 1 | Status access strobe |
| stat_clr | input | 2 | Write-one-to-clear mask: bit 0 underflow, bit 1 overwrite |
| under_en | input | 1 | Underflow interrupt enable |
| over_en | input | 1 | Overwrite interrupt enable and halting policy |
| flag_under | output | 1 | Sticky underflow flag |
| flag_over | output | 1 | Overwrite flag |
| irq | output | 1 | Level interrupt |
| level | output | $clog2(DEPTH+1) | Occupancy |

## Verification
The bench fills the queue to the brim and offers one more result under each policy. A design that drops the extra word, or writes it over the oldest entry, breaks the drain order. Under the halting policy the bench reads one word and then offers another result while stalled. A design that writes during the halt, or accepts the stalled strobe, shows a wrong `level` or an unexpected word. It also issues a clear in the same cycle as an empty read to catch a clear that beats the set, and it reads and writes together at full occupancy to catch a spurious overwrite flag or a shifted count.

// File: rtl/rsfifo_pkg.sv
package rsfifo_pkg;
  localparam int CLR_UNDER_BIT = 0;
  localparam int CLR_OVER_BIT  = 1;
  localparam int CLR_W         = 2;
endpackage

// File: rtl/rsfifo_mem.sv
module rsfifo_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] ram [DEPTH];

  // read-before-write: a full-queue read and write to the same slot returns old data
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) q <= ram[raddr];
  end
endmodule

// File: rtl/rsfifo_ptr.sv
module rsfifo_ptr #(
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] waddr,
  output logic [PTR_W-1:0] raddr,
  output logic [LVL_W-1:0] level
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr <= '0;
      raddr <= '0;
      level <= '0;
    end else begin
      if (push) waddr <= bump(waddr);
      if (pop)  raddr <= bump(raddr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rsfifo_flags.sv
module rsfifo_flags #(
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             under_evt,
  input  logic             over_evt,
  input  logic             room_evt,
  input  logic             clr_under,
  input  logic             clr_over,
  input  logic             over_en,
  output logic             flag_under,
  output logic             flag_over
);
  logic auto_clr;
  assign auto_clr = !over_en && room_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_under <= 1'b0;
      flag_over  <= 1'b0;
    end else begin
      flag_under <= under_evt | (flag_under & ~clr_under);
      flag_over  <= over_evt  | (flag_over & ~(clr_over | auto_clr));
    end
  end
endmodule

// File: rtl/rsfifo_top.sv
module rsfifo_top #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prod_valid,
  input  logic [DATA_W-1:0] prod_data,
  output logic              prod_stall,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_wr,
  input  logic [1:0]        stat_clr,
  input  logic              under_en,
  input  logic              over_en,
  output logic              flag_under,
  output logic              flag_over,
  output logic              irq,
  output logic [LVL_W-1:0]  level
);
  import rsfifo_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic              hold_v;
  logic [DATA_W-1:0] hold_d;
  logic              halted, accept, empty, full, pop, push, cand_v;
  logic [DATA_W-1:0] cand_d, mem_q;
  logic [PTR_W-1:0]  waddr, raddr;
  logic              zero_sel;

  assign halted     = flag_over & over_en;
  assign prod_stall = hold_v | halted;
  assign accept     = prod_valid & ~prod_stall;
  assign empty      = (level == '0);
  assign full       = (level == FULL_LVL);
  assign pop        = rd_en & ~empty;
  assign cand_v     = hold_v | accept;
  assign cand_d     = hold_v ? hold_d : prod_data;
  assign push       = cand_v & ~halted & (~full | pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (accept && !push) begin
      hold_v <= 1'b1;
      hold_d <= prod_data;
    end else if (hold_v && push) begin
      hold_v <= 1'b0;
    end
  end

  rsfifo_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .waddr(waddr), .raddr(raddr), .level(level)
  );

  rsfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .we(push), .waddr(waddr), .wdata(cand_d),
    .re(pop), .raddr(raddr), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst)        zero_sel <= 1'b1;
    else if (rd_en) zero_sel <= empty;
  end
  assign rd_data = zero_sel ? '0 : mem_q;

  rsfifo_flags #(.DEPTH(DEPTH)) flags_i (
    .clk(clk), .rst(rst),
    .under_evt(rd_en & empty),
    .over_evt(accept & full & ~pop),
    .room_evt(~full | pop),
    .clr_under(stat_wr & stat_clr[CLR_UNDER_BIT]),
    .clr_over(stat_wr & stat_clr[CLR_OVER_BIT]),
    .over_en(over_en),
    .flag_under(flag_under), .flag_over(flag_over)
  );

  assign irq = (flag_under & under_en) | (flag_over & over_en);
endmodule

// File: rtl/rsfifo_chk.sv
module rsfifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              prod_valid,
  input logic              prod_stall,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              stat_wr,
  input logic              over_en,
  input logic              flag_under,
  input logic              flag_over,
  input logic              irq,
  input logic [LVL_W-1:0]  level
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  p_under_set_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && level == '0 |=> flag_under && rd_data == '0);

  p_over_stall_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_over) |-> prod_stall);

  p_halt_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    flag_over && over_en && !stat_wr |=> level <= $past(level));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_under || flag_over));

  p_stalled_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    prod_stall && !rd_en |=> level <= $past(level) + 1'b1);
endmodule

bind rsfifo_top rsfifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .prod_valid(prod_valid), .prod_stall(prod_stall),
  .rd_en(rd_en), .rd_data(rd_data), .stat_wr(stat_wr), .over_en(over_en),
  .flag_under(flag_under), .flag_over(flag_over), .irq(irq), .level(level)
);

// File: tb/rsfifo_tb.sv
module rsfifo_top_tb_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prod_valid = 1'b0;
  logic [DATA_W-1:0] prod_data = '0;
  logic prod_stall;
  logic rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic stat_wr = 1'b0;
  logic [1:0] stat_clr = '0;
  logic under_en = 1'b0;
  logic over_en = 1'b0;
  logic flag_under, flag_over, irq;
  logic [LVL_W-1:0] level;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rsfifo_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .prod_valid(prod_valid), .prod_data(prod_data),
    .prod_stall(prod_stall), .rd_en(rd_en), .rd_data(rd_data),
    .stat_wr(stat_wr), .stat_clr(stat_clr), .under_en(under_en),
    .over_en(over_en), .flag_under(flag_under), .flag_over(flag_over),
    .irq(irq), .level(level)
  );

  typedef struct packed {
    logic              pv;
    logic [15:0]       d;
    logic              rd;
    logic [3:0]        lvl;
    logic [15:0]       rdat;
    logic              udf;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 16'hA001, 1'b0, 4'd1, 16'h0000, 1'b0},
    '{1'b1, 16'hA002, 1'b0, 4'd2, 16'h0000, 1'b0},
    '{1'b1, 16'hA003, 1'b1, 4'd2, 16'hA001, 1'b0},
    '{1'b0, 16'h0000, 1'b1, 4'd1, 16'hA002, 1'b0},
    '{1'b0, 16'h0000, 1'b1, 4'd0, 16'hA003, 1'b0},
    '{1'b0, 16'h0000, 1'b1, 4'd0, 16'h0000, 1'b1},
    '{1'b1, 16'hB001, 1'b0, 4'd1, 16'h0000, 1'b1},
    '{1'b0, 16'h0000, 1'b1, 4'd0, 16'hB001, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cycles++;
  endtask

  task automatic idle_inputs();
    prod_valid = 1'b0; rd_en = 1'b0; stat_wr = 1'b0; stat_clr = '0;
  endtask

  task automatic push_word(input logic [15:0] w);
    prod_valid = 1'b1; prod_data = w; step(); idle_inputs();
  endtask

  task automatic drain(input logic [15:0] base, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1; step(); idle_inputs();
      check(req, rd_data, base + 16'(i));
    end
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below 100000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1;
    step(); step(); rst = 1'b0;
    // R11 reset state
    check("R11 level", level, 0);
    check("R11 flags", {flag_under, flag_over, irq, prod_stall}, 0);
    check("R11 rd_data", rd_data, 0);

    under_en = 1'b1;
    for (int v = 0; v < 8; v++) begin
      prod_valid = VECS[v].pv; prod_data = VECS[v].d; rd_en = VECS[v].rd;
      step(); idle_inputs();
      check("R1 R7 level", level, VECS[v].lvl);
      check("R2 R3 rd_data", rd_data, VECS[v].rdat);
      check("R2 flag_under", flag_under, VECS[v].udf);
    end
    check("R9 irq under", irq, 1);
    under_en = 1'b0; #1;
    check("R9 irq gated", irq, 0);

    // R8 clear and set-wins
    rd_en = 1'b1; stat_wr = 1'b1; stat_clr = 2'b01; step(); idle_inputs();
    check("R8 set wins", flag_under, 1);
    stat_wr = 1'b1; stat_clr = 2'b10; step(); idle_inputs();
    check("R8 wrong bit keeps", flag_under, 1);
    stat_wr = 1'b1; stat_clr = 2'b01; step(); idle_inputs();
    check("R8 clear", flag_under, 0);

    // auto-recover policy, R6
    over_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) push_word(16'hC000 + 16'(i));
    check("R1 full level", level, DEPTH);
    push_word(16'hC008);
    check("R4 flag_over", flag_over, 1);
    check("R4 stall", prod_stall, 1);
    check("R4 level", level, DEPTH);
    check("R9 no irq oven0", irq, 0);
    rd_en = 1'b1; step(); idle_inputs();
    check("R6 rd_data", rd_data, 16'hC000);
    check("R6 level kept", level, DEPTH);
    check("R6 auto clear", flag_over, 0);
    check("R6 stall released", prod_stall, 0);
    // R7 read+write at full
    rd_en = 1'b1; prod_valid = 1'b1; prod_data = 16'hC009; step(); idle_inputs();
    check("R7 level", level, DEPTH);
    check("R7 no over", flag_over, 0);
    check("R7 rd_data", rd_data, 16'hC001);
    drain(16'hC002, DEPTH, "R1 R4 order");
    check("R1 empty", level, 0);

    // halting policy, R5
    over_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) push_word(16'hD000 + 16'(i));
    push_word(16'hD008);
    check("R5 flag_over", flag_over, 1);
    check("R9 irq over", irq, 1);
    rd_en = 1'b1; step(); idle_inputs();
    check("R5 rd_data", rd_data, 16'hD000);
    check("R5 no write", level, DEPTH - 1);
    check("R5 flag kept", flag_over, 1);
    check("R5 stall", prod_stall, 1);
    push_word(16'hEEEE);
    check("R10 ignored", level, DEPTH - 1);
    stat_wr = 1'b1; stat_clr = 2'b10; step(); idle_inputs();
    check("R8 over clear", flag_over, 0);
    step();
    check("R5 held written", level, DEPTH);
    check("R5 stall off", prod_stall, 0);
    drain(16'hD001, DEPTH, "R5 R10 order");
    check("R10 empty after drain", level, 0);

    // R11 reset mid-operation
    for (int i = 0; i < DEPTH; i++) push_word(16'hF000 + 16'(i));
    push_word(16'hF008);
    rd_en = 1'b1; step(); idle_inputs();
    rst = 1'b1; step(); rst = 1'b0;
    check("R11 level", level, 0);
    check("R11 flags", {flag_under, flag_over, prod_stall}, 0);
    check("R11 rd_data", rd_data, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule